// File: doc/BRIEF.md
# Flash Block Protection Register Unit

This unit keeps two small protection masks for a flash array split into 2 KB blocks: a read-enable mask, which gates reads and instruction fetches, and a program-enable mask, which gates writes and erases. Each mask has one bit per block, and a 1 means the access is open. Software sees both masks as 32-bit registers on a simple register bus. It can only clear bits in them, never set them.

Cleared bits are provisional until a commit strobe folds them into a modelled non-volatile store. A power-on reset reloads both masks from that store, so any clear that was never committed comes back. A warm reset leaves the masks untouched. An erase input on the store stands in for a factory-fresh part and brings the store back to all ones.

A separate access port takes a flash address and an access kind. It returns a combinational permit or deny for the block that the address falls in.

Top module: `flash_guard_regs`

## Requirements
- R1: When the store has been erased and the power-on reset has finished, both registers read 0x0000000F, and every access is permitted.
- R2: The read-enable mask sits at register offset 0x130 and the program-enable mask at 0x134. Read data appears on `reg_rdata` after the clock edge that samples a read request (`reg_sel`=1, `reg_wr`=0).
- R3: A register write (`reg_sel`=1, `reg_wr`=1) to a mapped offset makes the new mask equal to the old mask AND `reg_wdata[3:0]`. Writing 1 to a bit that is 0 leaves it 0.
- R4: Bits 31:4 of both registers read as zero, and write data in those bits has no effect.
- R5: A read of any offset other than 0x130 or 0x134 returns zero. A write to such an offset changes neither mask.
- R6: A `commit` pulse replaces the store with store AND live mask, for both masks. The store never gains a 1.
- R7: Once `por_n` is released, the live masks are reloaded from the store within a few cycles. Clears that were not committed are undone by this reload.
- R8: A committed clear survives later commits and later power-on resets.
- R9: A warm reset (`rst_n` low) keeps the live mask values, including clears that have not been committed.
- R10: The block index is `acc_addr[12:11]`. The access kinds are encoded 0 = read, 1 = execute, 2 = write, 3 = erase. A read or execute is denied (`acc_permit`=0) when the block's read-enable bit is 0. A write or erase is denied when the block's program-enable bit is 0. Otherwise the access is permitted.
- R11: While `por_n` is low, and until the reload has completed, every access is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| nv_erase_n | input | 1 | Active-low erase of the modelled store to all ones |
| por_n | input | 1 | Active-low power-on reset; the masks are reloaded after it is released |
| rst_n | input | 1 | Active-low warm reset; affects only the read port |
| reg_sel | input | 1 | Register access request |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| commit | input | 1 | Fold the live masks into the store |
| acc_addr | input | 13 | Flash byte address being checked |
| acc_kind | input | 2 | Access kind: 0 read, 1 execute, 2 write, 3 erase |
| acc_permit | output | 1 | 1 when the access is allowed |

## Verification
The bench writes 1s on top of bits that are already cleared. A design that replaced or ORed the mask would visibly re-open a block. It clears a bit without committing and then cycles the power-on reset; a design that reloaded nothing, or reloaded the factory value, would show the wrong mask afterwards. It also commits twice with different clears, to catch a commit that overwrites the store instead of ANDing into it. It pulses the warm reset to catch designs that wipe the masks, and it checks access decisions at each block boundary and for each access kind, which exposes a wrong address slice or a swapped mask.

// File: rtl/fbp_pkg.sv
`timescale 1ns/1ps
package fbp_pkg;
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_EXEC  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_ERASE = 2'd3
  } acc_kind_e;

  localparam int unsigned MASK_COUNT = 2;  // index 0: read enable, 1: program enable
endpackage

// File: rtl/fbp_reset_sync.sv
`timescale 1ns/1ps
// Asynchronous assertion, synchronous release.
module fbp_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], 1'b1} >> 0;
    chain_d = (chain_q << 1) | {{(STAGES-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/fbp_prot_bank.sv
`timescale 1ns/1ps
// One protection mask: live copy plus its modelled non-volatile copy.
module fbp_prot_bank #(
  parameter int unsigned NB = 4
) (
  input  logic          clk,
  input  logic          por_rst_n,
  input  logic          nv_rst_n,
  input  logic          wr_en,
  input  logic [NB-1:0] wr_mask,
  input  logic          commit,
  output logic [NB-1:0] live,
  output logic          loading
);
  logic [NB-1:0] store_q, store_d;
  logic [NB-1:0] live_q, live_d;
  logic          pend_q;
  logic          commit_ok;
  logic          live_en;

  // A commit while the reload is pending would fold zeros into the store.
  assign commit_ok = commit & ~pend_q;
  assign live_en   = pend_q | wr_en;

  always_comb begin
    store_d = store_q;
    if (commit_ok) store_d = store_q & live_q;
  end

  always_comb begin
    live_d = live_q;
    if (pend_q)     live_d = store_q;
    else if (wr_en) live_d = live_q & wr_mask;
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n)      store_q <= '1;
    else if (commit_ok) store_q <= store_d;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)   live_q <= '0;
    else if (live_en) live_q <= live_d;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) pend_q <= 1'b1;
    else            pend_q <= 1'b0;
  end

  assign live    = live_q;
  assign loading = pend_q;

  // R3: outside the reload, the live mask never gains a 1
  a_r3_clear_only: assert property (@(posedge clk) disable iff (!por_rst_n)
    !pend_q |=> ((live_q & ~$past(live_q)) == '0));

  // R7: the reload copies the store
  a_r7_reload: assert property (@(posedge clk) disable iff (!por_rst_n || !nv_rst_n)
    pend_q |=> (live_q == $past(store_q)));

  // R6: the store never gains a 1
  a_r6_store_no_gain: assert property (@(posedge clk) disable iff (!nv_rst_n)
    1'b1 |=> ((store_q & ~$past(store_q)) == '0));

  // R8: the store changes only on an accepted commit
  a_r8_store_hold: assert property (@(posedge clk) disable iff (!nv_rst_n)
    !commit_ok |=> $stable(store_q));
endmodule

// File: rtl/fbp_bus_if.sv
`timescale 1ns/1ps
// Register decode, write enables and the registered read port.
module fbp_bus_if #(
  parameter int unsigned          NB     = 4,
  parameter int unsigned          DW     = 32,
  parameter int unsigned          AW     = 12,
  parameter logic [AW-1:0]        OFF_RE = 12'h130,
  parameter logic [AW-1:0]        OFF_PE = 12'h134
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] live_re,
  input  logic [NB-1:0] live_pe,
  output logic          re_we,
  output logic          pe_we,
  output logic [NB-1:0] wr_mask,
  output logic [DW-1:0] rdata
);
  logic          hit_re, hit_pe;
  logic          rd_en;
  logic [DW-1:0] rdata_d;
  logic          unused_wdata_hi;

  assign hit_re = (addr == OFF_RE);
  assign hit_pe = (addr == OFF_PE);
  assign rd_en  = sel & ~wr;
  assign re_we  = sel & wr & hit_re;
  assign pe_we  = sel & wr & hit_pe;
  assign wr_mask = wdata[NB-1:0];
  assign unused_wdata_hi = ^wdata[DW-1:NB];

  always_comb begin
    rdata_d = '0;
    if (hit_re)      rdata_d[NB-1:0] = live_re;
    else if (hit_pe) rdata_d[NB-1:0] = live_pe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rdata_d;
  end

  // R5: unmapped reads return zero
  a_r5_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_re && !hit_pe) |=> (rdata == '0));

  // R4: reserved bits of read data stay zero after any read
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rdata[DW-1:NB] == '0));
endmodule

// File: rtl/fbp_access_check.sv
`timescale 1ns/1ps
// Combinational permit/deny for one flash access.
module fbp_access_check
  import fbp_pkg::*;
#(
  parameter int unsigned NB      = 4,
  parameter int unsigned AW      = 13,
  parameter int unsigned BLK_LSB = 11
) (
  input  logic [AW-1:0] acc_addr,
  input  acc_kind_e     kind,
  input  logic [NB-1:0] live_re,
  input  logic [NB-1:0] live_pe,
  output logic          permit
);
  localparam int unsigned IDX_W = (NB > 1) ? $clog2(NB) : 1;

  logic [IDX_W-1:0] blk_idx;
  logic             unused_addr_lo;

  assign blk_idx        = acc_addr[BLK_LSB +: IDX_W];
  assign unused_addr_lo = ^acc_addr[BLK_LSB-1:0];

  always_comb begin
    unique case (kind)
      ACC_READ, ACC_EXEC:   permit = live_re[blk_idx];
      ACC_WRITE, ACC_ERASE: permit = live_pe[blk_idx];
      default:              permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/flash_guard_regs.sv
`timescale 1ns/1ps
module flash_guard_regs
  import fbp_pkg::*;
#(
  parameter int unsigned   NUM_BLOCKS = 4,
  parameter int unsigned   DATA_W     = 32,
  parameter int unsigned   REG_AW     = 12,
  parameter logic [11:0]   OFF_RE     = 12'h130,
  parameter logic [11:0]   OFF_PE     = 12'h134,
  parameter int unsigned   BLOCK_LSB  = 11,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic                                    clk,
  input  logic                                    nv_erase_n,
  input  logic                                    por_n,
  input  logic                                    rst_n,
  input  logic                                    reg_sel,
  input  logic                                    reg_wr,
  input  logic [REG_AW-1:0]                       reg_addr,
  input  logic [DATA_W-1:0]                       reg_wdata,
  output logic [DATA_W-1:0]                       reg_rdata,
  input  logic                                    commit,
  input  logic [BLOCK_LSB+$clog2(NUM_BLOCKS)-1:0] acc_addr,
  input  logic [1:0]                              acc_kind,
  output logic                                    acc_permit
);
  localparam int unsigned ACC_AW = BLOCK_LSB + $clog2(NUM_BLOCKS);

  logic nv_s_n, por_s_n, warm_s_n, rd_rst_n;
  logic re_we, pe_we;
  logic [NUM_BLOCKS-1:0] wr_mask;
  logic [MASK_COUNT-1:0] bank_we;
  logic [MASK_COUNT-1:0] loading;
  logic [MASK_COUNT-1:0][NUM_BLOCKS-1:0] live;

  fbp_reset_sync #(.STAGES(SYNC_STAGES)) u_sync_nv (
    .clk(clk), .arst_n(nv_erase_n), .srst_n(nv_s_n));
  fbp_reset_sync #(.STAGES(SYNC_STAGES)) u_sync_por (
    .clk(clk), .arst_n(por_n), .srst_n(por_s_n));
  fbp_reset_sync #(.STAGES(SYNC_STAGES)) u_sync_warm (
    .clk(clk), .arst_n(rst_n & por_n), .srst_n(warm_s_n));

  assign rd_rst_n = warm_s_n & por_s_n;

  fbp_bus_if #(
    .NB(NUM_BLOCKS), .DW(DATA_W), .AW(REG_AW), .OFF_RE(OFF_RE), .OFF_PE(OFF_PE)
  ) u_bus (
    .clk(clk), .rst_n(rd_rst_n), .sel(reg_sel), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .live_re(live[0]), .live_pe(live[1]),
    .re_we(re_we), .pe_we(pe_we), .wr_mask(wr_mask), .rdata(reg_rdata));

  assign bank_we = {pe_we, re_we};

  for (genvar g = 0; g < MASK_COUNT; g++) begin : g_bank
    fbp_prot_bank #(.NB(NUM_BLOCKS)) u_bank (
      .clk(clk), .por_rst_n(por_s_n), .nv_rst_n(nv_s_n),
      .wr_en(bank_we[g]), .wr_mask(wr_mask), .commit(commit),
      .live(live[g]), .loading(loading[g]));
  end

  fbp_access_check #(.NB(NUM_BLOCKS), .AW(ACC_AW), .BLK_LSB(BLOCK_LSB)) u_acc (
    .acc_addr(acc_addr), .kind(acc_kind_e'(acc_kind)),
    .live_re(live[0]), .live_pe(live[1]), .permit(acc_permit));

  // R10 / R11: with both masks closed (as during power-on reset) nothing is allowed
  a_r11_closed_denies: assert property (@(posedge clk) disable iff (!nv_s_n)
    ((live[0] == '0) && (live[1] == '0)) |-> !acc_permit);

  // R5: a write to an unmapped offset leaves both masks alone
  a_r5_unmapped_write: assert property (@(posedge clk) disable iff (!por_s_n)
    (reg_sel && reg_wr && !re_we && !pe_we && (loading == '0)) |=> $stable(live));

  // R9: a warm reset by itself never touches the masks
  a_r9_warm_keeps: assert property (@(posedge clk) disable iff (!por_s_n)
    (!warm_s_n && !reg_sel && (loading == '0)) |=> $stable(live));
endmodule

// File: tb/flash_guard_regs_tb_top.sv
`timescale 1ns/1ps
module flash_guard_regs_tb_top;
  localparam int unsigned OP_WR = 0, OP_RD = 1, OP_ACC = 2, OP_CMT = 3, OP_POR = 4;

  typedef struct packed {
    logic [2:0]  op;
    logic [12:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    '{3'd1, 13'h130, 32'h0,        32'hF, 8'd1},   // R1 read enable factory
    '{3'd1, 13'h134, 32'h0,        32'hF, 8'd1},   // R1 program enable factory
    '{3'd2, 13'h0000, 32'd0,       32'd1, 8'd1},   // R1 open access
    '{3'd0, 13'h130, 32'hFFFFFFFE, 32'h0, 8'd3},   // R3 clear bit0
    '{3'd1, 13'h130, 32'h0,        32'hE, 8'd3},   // R2 R3
    '{3'd2, 13'h0000, 32'd1,       32'd0, 8'd10},  // R10 exec blk0 denied
    '{3'd2, 13'h0800, 32'd0,       32'd1, 8'd10},  // R10 read blk1 ok
    '{3'd0, 13'h130, 32'hFFFFFFFF, 32'h0, 8'd3},   // R3 write ones
    '{3'd1, 13'h130, 32'h0,        32'hE, 8'd3},   // R3 R4 still E
    '{3'd0, 13'h134, 32'hFFFFFFF7, 32'h0, 8'd3},   // R3 clear pe bit3
    '{3'd2, 13'h1800, 32'd2,       32'd0, 8'd10},  // R10 write blk3 denied
    '{3'd2, 13'h1800, 32'd3,       32'd0, 8'd10},  // R10 erase blk3 denied
    '{3'd2, 13'h1800, 32'd0,       32'd1, 8'd10},  // R10 read blk3 ok
    '{3'd0, 13'h138, 32'h0,        32'h0, 8'd5},   // R5 unmapped write
    '{3'd1, 13'h138, 32'h0,        32'h0, 8'd5},   // R5 unmapped read
    '{3'd1, 13'h130, 32'h0,        32'hE, 8'd5},   // R5 re untouched
    '{3'd1, 13'h134, 32'h0,        32'h7, 8'd5},   // R5 pe untouched
    '{3'd3, 13'h0,   32'h0,        32'h0, 8'd6},   // R6 commit
    '{3'd0, 13'h130, 32'hFFFFFFFB, 32'h0, 8'd7},   // R7 uncommitted clear
    '{3'd1, 13'h130, 32'h0,        32'hA, 8'd7},   // R7 live shows A
    '{3'd4, 13'h0,   32'h0,        32'h0, 8'd7},   // R7 power-on reset
    '{3'd1, 13'h130, 32'h0,        32'hE, 8'd7},   // R7 reload undid clear
    '{3'd1, 13'h134, 32'h0,        32'h7, 8'd8},   // R8 committed clear kept
    '{3'd0, 13'h134, 32'hFFFFFFFD, 32'h0, 8'd6},   // R6 clear pe bit1
    '{3'd3, 13'h0,   32'h0,        32'h0, 8'd6},   // R6 second commit
    '{3'd4, 13'h0,   32'h0,        32'h0, 8'd8},   // R8 power-on reset
    '{3'd1, 13'h134, 32'h0,        32'h5, 8'd8},   // R8 both clears kept
    '{3'd1, 13'h130, 32'h0,        32'hE, 8'd8},   // R8
    '{3'd2, 13'h1000, 32'd2,       32'd1, 8'd10},  // R10 write blk2 ok
    '{3'd2, 13'h0800, 32'd3,       32'd0, 8'd10}   // R10 erase blk1 denied
  };

  logic        clk = 1'b0;
  logic        nv_erase_n, por_n, rst_n;
  logic        reg_sel, reg_wr, commit;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [12:0] acc_addr;
  logic [1:0]  acc_kind;
  logic        acc_permit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  flash_guard_regs dut_i (
    .clk(clk), .nv_erase_n(nv_erase_n), .por_n(por_n), .rst_n(rst_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .commit(commit), .acc_addr(acc_addr), .acc_kind(acc_kind),
    .acc_permit(acc_permit));

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk); reg_sel = 1'b0; d = reg_rdata;
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1'b1;
    @(negedge clk); commit = 1'b0;
  endtask

  task automatic do_por();
    @(negedge clk); por_n = 1'b0;
    wait_cycles(3);
    por_n = 1'b1;
    wait_cycles(6);
  endtask

  task automatic do_acc(input logic [12:0] a, input logic [1:0] k, output logic p);
    @(negedge clk); acc_addr = a; acc_kind = k;
    #1 p = acc_permit;
  endtask

  initial begin
    #(8ns * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic        p;
    nv_erase_n = 1'b0; por_n = 1'b0; rst_n = 1'b0;
    reg_sel = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    commit = 1'b0; acc_addr = '0; acc_kind = '0;
    wait_cycles(3);
    nv_erase_n = 1'b1; por_n = 1'b1; rst_n = 1'b1;
    wait_cycles(6);

    // R2: reset state of the read port before any read
    check(2, reg_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        3'(OP_WR):  do_write(VEC[i].addr[11:0], VEC[i].data);
        3'(OP_RD):  begin
                      do_read(VEC[i].addr[11:0], rd);
                      check(int'(VEC[i].req), rd, VEC[i].exp);
                    end
        3'(OP_ACC): begin
                      do_acc(VEC[i].addr, VEC[i].data[1:0], p);
                      check(int'(VEC[i].req), {31'd0, p}, VEC[i].exp);
                    end
        3'(OP_CMT): do_commit();
        3'(OP_POR): do_por();
        default: ;
      endcase
    end

    // R4: upper write data bits are ignored, upper read bits stay zero
    do_write(12'h130, 32'h0000000F);
    do_read(12'h130, rd);
    check(4, rd, 32'h0000000E);

    // R9: warm reset keeps an uncommitted clear
    do_write(12'h130, 32'hFFFFFFF7);
    @(negedge clk); rst_n = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(4);
    do_read(12'h130, rd);
    check(9, rd, 32'h00000006);

    // R11: everything denied while power-on reset is held
    @(negedge clk); por_n = 1'b0;
    do_acc(13'h0800, 2'd0, p);
    check(11, {31'd0, p}, 32'd0);
    do_acc(13'h1000, 2'd2, p);
    check(11, {31'd0, p}, 32'd0);
    wait_cycles(2);
    por_n = 1'b1;
    wait_cycles(6);
    // R7: reload restores committed read mask E, so blk1 reads allowed again
    do_acc(13'h0800, 2'd0, p);
    check(7, {31'd0, p}, 32'd1);
    do_read(12'h130, rd);
    check(7, rd, 32'h0000000E);

    // R1: erasing the store and cycling power-on reset reopens everything
    @(negedge clk); nv_erase_n = 1'b0; por_n = 1'b0;
    wait_cycles(3);
    nv_erase_n = 1'b1; por_n = 1'b1;
    wait_cycles(6);
    do_read(12'h134, rd);
    check(1, rd, 32'h0000000F);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule